// File: doc/BRIEF.md
# CPU Clock-Domain Divider and Source Control

This block is the register-visible control point for the clocks of one CPU domain. It holds a source-select word that picks between the main PLL path and an alternate source, plus two divider configuration words with four 3-bit ratio fields: core, trace-bus, copy and monitor. A status word reports which source the domain is actually running from, and two further status words show which divider fields are still settling. The divided clocks are not real clocks. Each one appears as a clock-enable pulse that a downstream gating cell would consume.

Software writes a new ratio or a new source through a plain write port addressed by byte offset. It then polls the matching status offset until the field reads as settled. A changed ratio does not take effect in the enable output until its settle window ends. A source change passes through a visible "moving" state before the status shows the new source. Reads are combinational from the read address.

Top module: `cpuclk_ctrl_unit`

## Requirements
- R1: After reset all configuration words read 0, both divider status words read 0, the source status reads 0x00010000, `src_alt` is 0, and every enable output is high on every cycle.
- R2: The configuration words sit at byte offsets 0x000 (source select), 0x300 (divider word 0) and 0x304 (divider word 1). Word 0 holds the core ratio in [2:0] and the trace ratio in [18:16]. Word 1 holds the copy ratio in [2:0] and the monitor ratio in [6:4]. The source select holds the alternate-source bit at 16 and the monitor-path bit at 20. Every other bit reads 0, whatever was written to it.
- R3: An applied ratio N makes its enable output pulse once every N+1 cycles. For example, N=0 gives a pulse every cycle and N=7 gives divide by 8.
- R4: A write that changes a ratio field sets that field's busy bit for exactly SETTLE_CYC cycles (default 4). The busy bits are at 0x400 bit 0 (core), 0x400 bit 16 (trace), 0x404 bit 0 (copy) and 0x404 bit 4 (monitor). A write of the value already held leaves the busy bit at 0.
- R5: While a field is busy, its enable output keeps running at the previous ratio. The new ratio applies on the first cycle in which the busy bit reads 0.
- R6: The source status at 0x200 bits [18:16] reads 1 while the main PLL is active, 2 while the alternate source is active, and 4 for MUX_SETTLE_CYC cycles (default 3) after a write that flips select bit 16. `src_alt` is high only while the code reads 2.
- R7: Writes to the status offsets 0x200, 0x400 and 0x404, and to any unmapped offset, change no register or status.
- R8: Select bit 20 is stored and read back. It has no effect on the source status or on any divider.
- R9: A changing write to a field that is still busy restarts its settle window, which then runs a full SETTLE_CYC cycles from the later write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| core_ce | output | 1 | Core clock enable pulse |
| trace_ce | output | 1 | Trace-bus clock enable pulse |
| copy_ce | output | 1 | Copy clock enable pulse |
| mon_ce | output | 1 | Monitor clock enable pulse |
| src_alt | output | 1 | High while the alternate source is the settled source |

## Verification
A settle counter that is off by one shows up at a status offset within a cycle. The busy bit or the moving code clears a cycle too early or too late relative to the write. A ratio that reaches the enable path too soon makes an enable pulse go missing during the busy window. A wrong applied ratio changes the number of pulses in an 840-cycle window, which is a multiple of every period from 1 to 8. It is therefore seen within one window of the settle. A lost or stray register update shows at the next readback of the configuration words.

// File: rtl/cpuclk_pkg.sv
`timescale 1ns/1ps
// Shared constants, offsets and field layout for the CPU clock control unit.
// Assumes byte offsets on a 12-bit address and 32-bit data words.
package cpuclk_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int DIV_W   = 3;
    localparam int NUM_DIV = 4;
    localparam int MUX_W   = 3;

    localparam logic [ADDR_W-1:0] OFS_SRC_SEL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SRC_STAT  = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_DIV_CFG0  = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_DIV_CFG1  = 12'h304;
    localparam logic [ADDR_W-1:0] OFS_DIV_STAT0 = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_DIV_STAT1 = 12'h404;

    localparam int SEL_ALT_BIT  = 16;
    localparam int SEL_MON_BIT  = 20;
    localparam int MUX_STAT_LSB = 16;

    typedef enum logic [MUX_W-1:0] {
        MUX_MAIN   = 3'd1,
        MUX_ALT    = 3'd2,
        MUX_MOVING = 3'd4
    } mux_code_e;

    // Lane order: 0 core, 1 trace, 2 copy, 3 monitor.
    function automatic int lane_lsb(input int lane);
        case (lane)
            0:       return 0;
            1:       return 16;
            2:       return 0;
            default: return 4;
        endcase
    endfunction

    // Which divider word (0 or 1) a lane belongs to.
    function automatic int lane_bank(input int lane);
        return (lane < 2) ? 0 : 1;
    endfunction

endpackage

// File: rtl/cpuclk_settle_timer.sv
`timescale 1ns/1ps
// Down-counter that models a settle window: busy for CYCLES cycles after start.
// A start while busy reloads the window. done pulses on the last busy cycle
// unless a start arrives in that same cycle. Assumes CYCLES >= 1.
module cpuclk_settle_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1)) && !start;

endmodule

// File: rtl/cpuclk_ce_gen.sv
`timescale 1ns/1ps
// Clock-enable generator: ce is high once every ratio+1 cycles.
// If the ratio drops below the running count, the next cycle pulses and restarts.
module cpuclk_ce_gen #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio,
    output logic         ce
);
    logic [W-1:0] cnt_q;

    assign ce = (cnt_q >= ratio);

    // Phase counter, cleared on every pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ce)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/cpuclk_div_lane.sv
`timescale 1ns/1ps
// One divider field: the programmed target, its settle timer, the applied ratio
// and its enable generator. Only a write that changes the value starts settling.
// The applied ratio takes the target when the window ends.
module cpuclk_div_lane #(
    parameter int DIV_W      = 3,
    parameter int SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic [DIV_W-1:0] target,
    output logic [DIV_W-1:0] applied,
    output logic             busy,
    output logic             ce
);
    logic [DIV_W-1:0] target_q;
    logic [DIV_W-1:0] applied_q;
    logic             start;
    logic             done;

    assign start = load && (load_val != target_q);

    // Programmed value as software sees it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            target_q <= '0;
        else if (load)
            target_q <= load_val;
    end

    cpuclk_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    // Ratio in effect, updated only when the settle window closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            applied_q <= '0;
        else if (done)
            applied_q <= target_q;
    end

    cpuclk_ce_gen #(.W(DIV_W)) u_ce (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (applied_q),
        .ce    (ce)
    );

    assign target  = target_q;
    assign applied = applied_q;

endmodule

// File: rtl/cpuclk_ctrl_unit.sv
`timescale 1ns/1ps
// CPU clock-domain control unit: the source select, two divider words, and
// status words that show divider settling and the actual source as a code.
// Assumes single-cycle writes. Reads are combinational from rd_addr.
module cpuclk_ctrl_unit
    import cpuclk_pkg::*;
#(
    parameter int SETTLE_CYC     = 4,
    parameter int MUX_SETTLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              core_ce,
    output logic              trace_ce,
    output logic              copy_ce,
    output logic              mon_ce,
    output logic              src_alt
);
    logic [NUM_DIV-1:0][DIV_W-1:0] div_target;
    logic [NUM_DIV-1:0][DIV_W-1:0] div_applied;
    logic [NUM_DIV-1:0]            div_busy;
    logic [NUM_DIV-1:0]            div_ce;

    // One lane per divider field.
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_lane
        localparam int                LSB     = lane_lsb(g);
        localparam logic [ADDR_W-1:0] CFG_OFS = (lane_bank(g) == 0) ? OFS_DIV_CFG0 : OFS_DIV_CFG1;
        logic lane_load;
        assign lane_load = wr_en && (wr_addr == CFG_OFS);

        cpuclk_div_lane #(.DIV_W(DIV_W), .SETTLE_CYC(SETTLE_CYC)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (lane_load),
            .load_val (wr_data[LSB +: DIV_W]),
            .target   (div_target[g]),
            .applied  (div_applied[g]),
            .busy     (div_busy[g]),
            .ce       (div_ce[g])
        );
    end

    assign core_ce  = div_ce[0];
    assign trace_ce = div_ce[1];
    assign copy_ce  = div_ce[2];
    assign mon_ce   = div_ce[3];

    logic             sel_alt_q;
    logic             mon_main_q;
    logic             active_alt_q;
    logic             src_hit;
    logic             mux_start;
    logic             mux_busy;
    logic             mux_done;
    logic [MUX_W-1:0] mux_code;

    assign src_hit   = wr_en && (wr_addr == OFS_SRC_SEL);
    assign mux_start = src_hit && (wr_data[SEL_ALT_BIT] != sel_alt_q);

    // Source-select register bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_alt_q  <= 1'b0;
            mon_main_q <= 1'b0;
        end else if (src_hit) begin
            sel_alt_q  <= wr_data[SEL_ALT_BIT];
            mon_main_q <= wr_data[SEL_MON_BIT];
        end
    end

    cpuclk_settle_timer #(.CYCLES(MUX_SETTLE_CYC)) u_mux_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mux_start),
        .busy  (mux_busy),
        .done  (mux_done)
    );

    // Actual source, updated when the switch completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_alt_q <= 1'b0;
        else if (mux_done)
            active_alt_q <= sel_alt_q;
    end

    // Source status code.
    always_comb begin
        if (mux_busy)
            mux_code = MUX_MOVING;
        else if (active_alt_q)
            mux_code = MUX_ALT;
        else
            mux_code = MUX_MAIN;
    end

    assign src_alt = !mux_busy && active_alt_q;

    logic [1:0][DATA_W-1:0] cfg_word;
    logic [1:0][DATA_W-1:0] stat_word;

    // Assemble divider words from the lane fields.
    always_comb begin
        cfg_word  = '0;
        stat_word = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            cfg_word[lane_bank(i)][lane_lsb(i) +: DIV_W] = div_target[i];
            stat_word[lane_bank(i)][lane_lsb(i)]         = div_busy[i];
        end
    end

    // Read decode; reserved bits and unmapped offsets read zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_SRC_SEL: begin
                rd_data[SEL_ALT_BIT] = sel_alt_q;
                rd_data[SEL_MON_BIT] = mon_main_q;
            end
            OFS_SRC_STAT:  rd_data[MUX_STAT_LSB +: MUX_W] = mux_code;
            OFS_DIV_CFG0:  rd_data = cfg_word[0];
            OFS_DIV_CFG1:  rd_data = cfg_word[1];
            OFS_DIV_STAT0: rd_data = stat_word[0];
            OFS_DIV_STAT1: rd_data = stat_word[1];
            default:       rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cpuclk_ctrl_unit_chk.sv
`timescale 1ns/1ps
// Assertion checker bound to cpuclk_ctrl_unit. It observes the lane targets,
// the applied ratios, the busy flags, the enables and the source status code.
module cpuclk_ctrl_unit_chk #(
    parameter int NF    = 4,
    parameter int DIV_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [NF-1:0][DIV_W-1:0] div_target,
    input logic [NF-1:0][DIV_W-1:0] div_applied,
    input logic [NF-1:0]          div_busy,
    input logic [NF-1:0]          div_ce,
    input logic [2:0]             mux_code,
    input logic                   sel_alt_q
);
    for (genvar g = 0; g < NF; g++) begin : g_chk
        p_busy_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (div_target[g] != $past(div_target[g])) |-> div_busy[g]);

        p_hold_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            div_busy[g] |=> (!div_busy[g] || $stable(div_applied[g])));

        p_ratio_zero_every_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (div_applied[g] == '0) |-> div_ce[g]);

        p_cfg_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(div_target[g]));
    end

    p_transit_on_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_alt_q != $past(sel_alt_q)) |-> (mux_code == 3'd4));

    p_code_single_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mux_code) == 1);

endmodule

bind cpuclk_ctrl_unit cpuclk_ctrl_unit_chk #(
    .NF    (cpuclk_pkg::NUM_DIV),
    .DIV_W (cpuclk_pkg::DIV_W)
) u_chk (.*);

// File: tb/cpuclk_ctrl_unit_bench.sv
`timescale 1ns/1ps
// Self-checking bench for cpuclk_ctrl_unit: a vector table, then directed tests.
module cpuclk_ctrl_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        core_ce, trace_ce, copy_ce, mon_ce, src_alt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cpuclk_ctrl_unit u_cpuclk_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .core_ce(core_ce), .trace_ce(trace_ce),
        .copy_ce(copy_ce), .mon_ce(mon_ce), .src_alt(src_alt)
    );

    // {write addr, write data, read addr, expected read}
    localparam logic [87:0] VEC [8] = '{
        {12'h300, 32'hFFFF_FFFF, 12'h300, 32'h0007_0007},  // R2 reserved bits
        {12'h304, 32'hFFFF_FFFF, 12'h304, 32'h0000_0077},  // R2
        {12'h000, 32'hFFFF_FFFF, 12'h000, 32'h0011_0000},  // R2 select bits
        {12'h300, 32'h0005_0002, 12'h300, 32'h0005_0002},  // R2
        {12'h304, 32'h0000_0031, 12'h304, 32'h0000_0031},  // R2
        {12'h000, 32'h0000_0000, 12'h000, 32'h0000_0000},  // R2
        {12'h400, 32'hFFFF_FFFF, 12'h300, 32'h0005_0002},  // R7 status write ignored
        {12'h004, 32'hFFFF_FFFF, 12'h000, 32'h0000_0000}   // R7 unmapped ignored
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    // Count enable pulses over 840 cycles (a multiple of every period 1..8).
    task automatic measure(output int c0, output int c1, output int c2, output int c3);
        c0 = 0; c1 = 0; c2 = 0; c3 = 0;
        for (int k = 0; k < 840; k++) begin
            @(negedge clk);
            c0 += int'(core_ce); c1 += int'(trace_ce);
            c2 += int'(copy_ce); c3 += int'(mon_ce);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        logic [31:0] d;
        int c0, c1, c2, c3;

        do_reset();
        // R1 reset state
        rd(12'h000, d); chk("R1 select", d, 32'h0);
        rd(12'h200, d); chk("R1 source status", d, 32'h0001_0000);
        rd(12'h300, d); chk("R1 cfg0", d, 32'h0);
        rd(12'h304, d); chk("R1 cfg1", d, 32'h0);
        rd(12'h400, d); chk("R1 stat0", d, 32'h0);
        rd(12'h404, d); chk("R1 stat1", d, 32'h0);
        chk("R1 src_alt", {31'b0, src_alt}, 32'h0);
        measure(c0, c1, c2, c3);
        chk("R1 core_ce every cycle", c0, 840);
        chk("R1 mon_ce every cycle", c3, 840);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            wr(VEC[v][87:76], VEC[v][75:44]);
            rd(VEC[v][43:32], d);
            chk("R2/R7 vector", d, VEC[v][31:0]);
            step(10);
        end
        rd(12'h400, d); chk("R7 stat0 after status write", d, 32'h0);

        do_reset();
        // R4 busy window on the core field
        wr(12'h300, 32'h0000_0003);
        rd(12'h400, d); chk("R4 core busy set", d, 32'h0000_0001);
        step(3);
        rd(12'h400, d); chk("R4 core busy last cycle", d, 32'h0000_0001);
        step(1);
        rd(12'h400, d); chk("R4 core busy cleared", d, 32'h0);
        // R4 trace field only
        wr(12'h300, 32'h0003_0003);
        rd(12'h400, d); chk("R4 trace busy only", d, 32'h0001_0000);
        step(5);
        // R4 same-value write
        wr(12'h300, 32'h0003_0003);
        rd(12'h400, d); chk("R4 same value no busy", d, 32'h0);
        // R4 word-1 fields
        wr(12'h304, 32'h0000_0010);
        rd(12'h404, d); chk("R4 monitor busy bit 4", d, 32'h0000_0010);
        step(5);
        wr(12'h304, 32'h0000_0011);
        rd(12'h404, d); chk("R4 copy busy bit 0", d, 32'h0000_0001);
        step(5);

        // R5 old ratio 0 keeps running during busy
        wr(12'h300, 32'h0);
        step(6);
        wr(12'h300, 32'h0000_0007);
        for (int k = 0; k < 4; k++) begin
            chk("R5 core_ce at old ratio", {31'b0, core_ce}, 32'h1);
            if (k < 3) step(1);
        end
        step(2);
        measure(c0, c1, c2, c3);
        chk("R5 core new ratio 7 after settle", c0, 105);

        // R3 ratios on all four lanes
        wr(12'h300, 32'h0005_0002);
        wr(12'h304, 32'h0000_0076);
        step(6);
        measure(c0, c1, c2, c3);
        chk("R3 core divide by 3", c0, 280);
        chk("R3 trace divide by 6", c1, 140);
        chk("R3 copy divide by 7", c2, 120);
        chk("R3 monitor divide by 8", c3, 105);

        // R9 restart of the settle window
        wr(12'h300, 32'h0005_0001);
        step(2);
        wr(12'h300, 32'h0005_0004);
        rd(12'h400, d); chk("R9 busy after rewrite", d, 32'h1);
        step(3);
        rd(12'h400, d); chk("R9 busy full window", d, 32'h1);
        step(1);
        rd(12'h400, d); chk("R9 busy cleared", d, 32'h0);
        rd(12'h300, d); chk("R9 final value", d, 32'h0005_0004);

        // R6 source switch to alternate and back
        wr(12'h000, 32'h0001_0000);
        rd(12'h200, d); chk("R6 moving code", d, 32'h0004_0000);
        chk("R6 src_alt low in transit", {31'b0, src_alt}, 32'h0);
        step(2);
        rd(12'h200, d); chk("R6 moving last cycle", d, 32'h0004_0000);
        step(1);
        rd(12'h200, d); chk("R6 alternate code", d, 32'h0002_0000);
        chk("R6 src_alt high", {31'b0, src_alt}, 32'h1);
        wr(12'h000, 32'h0000_0000);
        rd(12'h200, d); chk("R6 moving back", d, 32'h0004_0000);
        step(3);
        rd(12'h200, d); chk("R6 main code", d, 32'h0001_0000);
        chk("R6 src_alt low", {31'b0, src_alt}, 32'h0);

        // R8 monitor-path bit has no side effect
        wr(12'h000, 32'h0010_0000);
        rd(12'h200, d); chk("R8 no transit", d, 32'h0001_0000);
        rd(12'h400, d); chk("R8 no divider busy", d, 32'h0);
        rd(12'h000, d); chk("R8 readback", d, 32'h0010_0000);
        step(5);
        rd(12'h200, d); chk("R8 source unchanged", d, 32'h0001_0000);

        done = 1'b1;
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule